// File: doc/BRIEF.md
# DRAM Retention Test Sequencer

This block drives characterization runs against a DRAM through a memory controller's command port. Each run takes a block of consecutive line addresses. For each line it writes a data pattern, leaves the line idle for a programmed retention interval, then reads it back and compares the result with the pattern. The row-activate, column and precharge commands are spaced by programmed activate-to-column, activate-to-precharge, write-recovery and precharge-to-activate times. Sweeping these times against the idle interval shows which reduced timings still give error-free data. A longer idle interval leaves less charge in the cells, so it stresses the timings harder.

Up to a parameter number of lines (eight by default) are in flight together, and each occupies a slot that holds its address and its own idle timer. While some lines are waiting, the single command engine writes new lines and verifies lines whose interval has run out. Activity on neighbouring lines therefore overlaps each verify, which adds supply noise and coupling that a one-line-at-a-time test never creates. The idle timer counts ticks from a programmable prescaler, so the real interval range of 64 ms to 512 ms can be shortened to a few cycles in simulation. Verify reads regenerate the expected pattern from the line address, so no written data is stored. Mismatching lines are counted, and the address of the first one is kept.

Top module: `dram_retention_seq`

## Requirements
- R1: After reset, `busy`, `done` and `cmd_valid` are 0, and `err_count` and `first_fail_addr` are 0.
- R2: Every line access is issued as a group of three accepted commands: an activate (`cmd_op` 0), then one write (1) or read (2) to the same `cmd_addr`, then a precharge (3). No other command comes between them.
- R3: At least `cfg_trcd` clock cycles pass between the accept of an activate and the accept of the column command that follows it.
- R4: At least `cfg_tras` cycles pass between the accept of an activate and the accept of its precharge.
- R5: After a write, at least `cfg_twr` cycles pass between the accept of the write and the accept of the precharge.
- R6: At least `cfg_trp` cycles pass between the accept of a precharge and the accept of the next activate.
- R7: Write data for line address A follows `cfg_pattern`: 0 gives all zeros. 1 gives all ones. 2 gives 0xAAAA… when A is even and 0x5555… when A is odd. 3 gives a pseudo-random word: s = A replicated across the word, XOR 0x9E3779B9 replicated, then s ^= s<<13, s ^= s>>7, s ^= s<<17.
- R8: A run with L lines writes each address from `cfg_base` to `cfg_base`+L−1 exactly once, and reads each of them exactly once after its write.
- R9: With an idle count W > 0 and a prescale P, at least (W−1)·(P+1) cycles pass between the accept of a line's write and the accept of its verify read.
- R10: No more than NSLOT lines are ever written but not yet read. When the idle interval is long enough, NSLOT lines are outstanding at once.
- R11: Each verify read whose returned data differs in any bit from the regenerated pattern adds one to `err_count`, which saturates at its maximum value. `first_fail_addr` holds the address of the first such line in the run.
- R12: A `start` pulse while idle clears `done`, `err_count` and `first_fail_addr` and raises `busy`. `done` rises only after every verify has completed. `busy` falls in the same cycle. While `done` is high, no command is issued. A run of zero lines finishes with no commands.
- R13: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when idle |
| cfg_pattern | input | 2 | Data pattern select |
| cfg_base | input | AW | First line address |
| cfg_lines | input | LCW | Number of lines in the run |
| cfg_wait | input | TW | Idle interval in prescaler ticks |
| cfg_prescale | input | PW | Tick period minus one, in cycles |
| cfg_trcd | input | TCW | Activate-to-column cycles |
| cfg_tras | input | TCW | Activate-to-precharge cycles |
| cfg_twr | input | TCW | Write-to-precharge cycles |
| cfg_trp | input | TCW | Precharge-to-activate cycles |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Controller accepts the command |
| cmd_op | output | 2 | 0 activate, 1 write, 2 read, 3 precharge |
| cmd_addr | output | AW | Line address |
| cmd_wdata | output | DW | Write data |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | DW | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| err_count | output | ERRW | Lines that failed verify |
| first_fail_addr | output | AW | Address of the first failing line |

## Verification
The timing assertions assume that the four timing inputs do not change while a run is in progress, because the checker measures command gaps against their present values. The counter properties assume that the controller returns exactly one `rd_data` strobe for each accepted read, and only after that read. The bench changes configuration only between runs, while `busy` is low. Its memory model answers each read with one strobe after a random delay of zero to three cycles. It drives `cmd_ready` randomly at a per-run rate, so the command-hold behaviour is exercised often.

// File: rtl/dram_retention_seq.sv
module dram_retention_seq #(
  parameter int AW    = 16,
  parameter int DW    = 64,
  parameter int NSLOT = 8,
  parameter int LCW   = 16,
  parameter int TW    = 20,
  parameter int PW    = 16,
  parameter int TCW   = 6,
  parameter int ERRW  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      cfg_pattern,
  input  logic [AW-1:0]   cfg_base,
  input  logic [LCW-1:0]  cfg_lines,
  input  logic [TW-1:0]   cfg_wait,
  input  logic [PW-1:0]   cfg_prescale,
  input  logic [TCW-1:0]  cfg_trcd,
  input  logic [TCW-1:0]  cfg_tras,
  input  logic [TCW-1:0]  cfg_twr,
  input  logic [TCW-1:0]  cfg_trp,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic [1:0]      cmd_op,
  output logic [AW-1:0]   cmd_addr,
  output logic [DW-1:0]   cmd_wdata,
  input  logic            rd_valid,
  input  logic [DW-1:0]   rd_data,
  output logic            busy,
  output logic            done,
  output logic [ERRW-1:0] err_count,
  output logic [AW-1:0]   first_fail_addr
);
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [1:0] OP_ACT = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_PRE = 2'd3;

  typedef enum logic [1:0] {S_FREE, S_OP, S_WAIT, S_DUE} slot_t;
  typedef enum logic [2:0] {E_IDLE, E_ACT, E_COL, E_RDATA, E_PRE, E_RP} eng_t;

  function automatic logic [DW-1:0] pat_gen(input logic [1:0] sel, input logic [AW-1:0] a);
    logic [DW-1:0] x;
    case (sel)
      2'd0: x = '0;
      2'd1: x = '1;
      2'd2: x = a[0] ? {(DW/2){2'b01}} : {(DW/2){2'b10}};
      default: begin
        x = {(DW/AW){a}} ^ {(DW/32){32'h9E3779B9}};
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
      end
    endcase
    return x;
  endfunction

  eng_t             eng;
  logic [SW-1:0]    cur_slot;
  logic             cur_wr;
  logic [AW-1:0]    cur_addr;
  logic [TCW-1:0]   act_age, col_age, pre_age;
  logic [PW-1:0]    pre_cnt;
  logic [LCW-1:0]   issued;
  slot_t            slot_st   [NSLOT];
  logic [AW-1:0]    slot_addr [NSLOT];
  logic [TW-1:0]    slot_tmr  [NSLOT];

  logic             due_any, free_any, all_free;
  logic [SW-1:0]    due_idx, free_idx;
  logic             tick, acc;
  logic [DW-1:0]    pat_exp;

  always_comb begin
    due_any  = 1'b0;
    free_any = 1'b0;
    all_free = 1'b1;
    due_idx  = '0;
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_st[i] == S_DUE) begin
        due_any = 1'b1;
        due_idx = SW'(i);
      end
      if (slot_st[i] == S_FREE) begin
        free_any = 1'b1;
        free_idx = SW'(i);
      end else begin
        all_free = 1'b0;
      end
    end
  end

  assign tick      = (pre_cnt == cfg_prescale);
  assign pat_exp   = pat_gen(cfg_pattern, cur_addr);
  assign cmd_addr  = cur_addr;
  assign cmd_wdata = pat_exp;
  assign acc       = cmd_valid && cmd_ready;

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_ACT;
    case (eng)
      E_ACT: cmd_valid = 1'b1;
      E_COL: begin
        cmd_valid = (act_age >= cfg_trcd);
        cmd_op    = cur_wr ? OP_WR : OP_RD;
      end
      E_PRE: begin
        cmd_valid = (act_age >= cfg_tras) && (!cur_wr || col_age >= cfg_twr);
        cmd_op    = OP_PRE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng             <= E_IDLE;
      cur_slot        <= '0;
      cur_wr          <= 1'b0;
      cur_addr        <= '0;
      act_age         <= '1;
      col_age         <= '1;
      pre_age         <= '1;
      pre_cnt         <= '0;
      issued          <= '0;
      busy            <= 1'b0;
      done            <= 1'b0;
      err_count       <= '0;
      first_fail_addr <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        slot_st[i]   <= S_FREE;
        slot_addr[i] <= '0;
        slot_tmr[i]  <= '0;
      end
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + PW'(1);
      act_age <= (acc && cmd_op == OP_ACT) ? TCW'(1) : ((act_age == '1) ? act_age : act_age + TCW'(1));
      col_age <= (acc && (cmd_op == OP_WR || cmd_op == OP_RD)) ? TCW'(1) :
                 ((col_age == '1) ? col_age : col_age + TCW'(1));
      pre_age <= (acc && cmd_op == OP_PRE) ? TCW'(1) : ((pre_age == '1) ? pre_age : pre_age + TCW'(1));

      for (int i = 0; i < NSLOT; i++) begin
        if (slot_st[i] == S_WAIT) begin
          if (slot_tmr[i] == '0) slot_st[i] <= S_DUE;
          else if (tick)         slot_tmr[i] <= slot_tmr[i] - TW'(1);
        end
      end

      if (start && !busy) begin
        busy            <= 1'b1;
        done            <= 1'b0;
        issued          <= '0;
        err_count       <= '0;
        first_fail_addr <= '0;
        pre_cnt         <= '0;
      end else begin
        case (eng)
          E_IDLE: if (busy) begin
            if (due_any) begin
              cur_slot          <= due_idx;
              cur_addr          <= slot_addr[due_idx];
              cur_wr            <= 1'b0;
              slot_st[due_idx]  <= S_OP;
              eng               <= E_ACT;
            end else if (free_any && issued != cfg_lines) begin
              cur_slot          <= free_idx;
              cur_addr          <= cfg_base + AW'(issued);
              slot_addr[free_idx] <= cfg_base + AW'(issued);
              cur_wr            <= 1'b1;
              slot_st[free_idx] <= S_OP;
              issued            <= issued + LCW'(1);
              eng               <= E_ACT;
            end else if (all_free && issued == cfg_lines) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
          E_ACT: if (cmd_ready) eng <= E_COL;
          E_COL: if (acc) eng <= cur_wr ? E_PRE : E_RDATA;
          E_RDATA: if (rd_valid) begin
            if (rd_data != pat_exp) begin
              if (err_count != '1)  err_count <= err_count + ERRW'(1);
              if (err_count == '0)  first_fail_addr <= cur_addr;
            end
            eng <= E_PRE;
          end
          E_PRE: if (acc) eng <= E_RP;
          E_RP: if (pre_age >= cfg_trp) begin
            if (cur_wr) begin
              slot_st[cur_slot]  <= S_WAIT;
              slot_tmr[cur_slot] <= cfg_wait;
            end else begin
              slot_st[cur_slot]  <= S_FREE;
            end
            eng <= E_IDLE;
          end
          default: eng <= E_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dram_retention_seq_chk.sv
module dram_retention_seq_chk #(
  parameter int AW   = 16,
  parameter int TCW  = 6,
  parameter int ERRW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [1:0]      cmd_op,
  input logic [AW-1:0]   cmd_addr,
  input logic [TCW-1:0]  cfg_trcd,
  input logic [TCW-1:0]  cfg_tras,
  input logic [TCW-1:0]  cfg_twr,
  input logic [TCW-1:0]  cfg_trp,
  input logic            busy,
  input logic            done,
  input logic [ERRW-1:0] err_count
);
  logic [TCW-1:0] act_age, col_age, pre_age;
  logic           last_wr;
  logic           acc;
  assign acc = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_age <= '1;
      col_age <= '1;
      pre_age <= '1;
      last_wr <= 1'b0;
    end else begin
      act_age <= (acc && cmd_op == 2'd0) ? TCW'(1) : ((act_age == '1) ? act_age : act_age + TCW'(1));
      col_age <= (acc && cmd_op[0] != cmd_op[1]) ? TCW'(1) : ((col_age == '1) ? col_age : col_age + TCW'(1));
      pre_age <= (acc && cmd_op == 2'd3) ? TCW'(1) : ((pre_age == '1) ? pre_age : pre_age + TCW'(1));
      if (acc && cmd_op == 2'd1) last_wr <= 1'b1;
      else if (acc && cmd_op == 2'd2) last_wr <= 1'b0;
    end
  end

  a_r3_act_to_col: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_op == 2'd1 || cmd_op == 2'd2)) |-> act_age >= cfg_trcd);
  a_r4_act_to_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd3) |-> act_age >= cfg_tras);
  a_r5_wr_to_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd3 && last_wr) |-> col_age >= cfg_twr);
  a_r6_pre_to_act: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd0) |-> pre_age >= cfg_trp);
  a_r13_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr)));
  a_r11_err_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == '1 && !start) |=> err_count == '1);
  a_r11_err_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> err_count >= $past(err_count));
  a_r12_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r12_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);
endmodule

bind dram_retention_seq dram_retention_seq_chk #(.AW(AW), .TCW(TCW), .ERRW(ERRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras),
  .cfg_twr(cfg_twr), .cfg_trp(cfg_trp), .busy(busy), .done(done), .err_count(err_count)
);

// File: tb/tb_dram_retention_seq.sv
`timescale 1ns/1ps
module tb_dram_retention_seq;
  localparam int AW = 16, DW = 64, NSLOT = 8, LCW = 16, TW = 20, PW = 16, TCW = 6, ERRW = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] cfg_pattern = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [LCW-1:0] cfg_lines = '0;
  logic [TW-1:0] cfg_wait = '0;
  logic [PW-1:0] cfg_prescale = '0;
  logic [TCW-1:0] cfg_trcd = '0, cfg_tras = '0, cfg_twr = '0, cfg_trp = '0;
  logic cmd_ready = 1'b0, rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic cmd_valid, busy, done;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_addr, first_fail_addr;
  logic [DW-1:0] cmd_wdata;
  logic [ERRW-1:0] err_count;

  always #2 clk = ~clk;

  dram_retention_seq #(.AW(AW), .DW(DW), .NSLOT(NSLOT), .LCW(LCW), .TW(TW), .PW(PW), .TCW(TCW), .ERRW(ERRW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_pattern(cfg_pattern), .cfg_base(cfg_base),
    .cfg_lines(cfg_lines), .cfg_wait(cfg_wait), .cfg_prescale(cfg_prescale), .cfg_trcd(cfg_trcd),
    .cfg_tras(cfg_tras), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done), .err_count(err_count),
    .first_fail_addr(first_fail_addr));

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] exp_pat(input logic [1:0] sel, input logic [15:0] a);
    logic [63:0] s;
    if (sel == 2'd0) return 64'h0;
    if (sel == 2'd1) return 64'hFFFF_FFFF_FFFF_FFFF;
    if (sel == 2'd2) return a[0] ? 64'h5555_5555_5555_5555 : 64'hAAAA_AAAA_AAAA_AAAA;
    s = {a, a, a, a} ^ 64'h9E3779B9_9E3779B9;
    s = s ^ (s << 13);
    s = s ^ (s >> 7);
    s = s ^ (s << 17);
    return s;
  endfunction

  logic [63:0] mem [0:1023];
  logic [63:0] flip [0:1023];
  bit wr_seen [0:1023];
  bit rd_seen [0:1023];
  longint wr_t [0:1023];
  int phase = 0;
  longint t_act = 0, t_col = 0, t_pre = 0;
  logic [15:0] op_addr = '0;
  bit col_wr = 0, seen_pre = 0;
  int outstanding = 0, max_out = 0, reads_done = 0, writes_done = 0;
  int exp_err = 0;
  logic [15:0] exp_first = '0;
  int rd_delay = 0;
  bit rd_pend = 0;
  logic [15:0] rd_addr_q = '0;
  int ready_pct = 100;
  bit prev_stall = 0;
  logic [1:0] prev_op = '0;
  logic [15:0] prev_addr = '0;
  int base_i = 0, lines_i = 0, wait_i = 0, pre_i = 0;

  initial begin : mem_model
    forever begin
      @(negedge clk);
      cyc++;
      rd_valid = 1'b0;
      if (rd_pend) begin
        if (rd_delay == 0) begin
          rd_valid = 1'b1;
          rd_data  = mem[rd_addr_q[9:0]] ^ flip[rd_addr_q[9:0]];
          if (flip[rd_addr_q[9:0]] != 64'h0) begin
            if (exp_err == 0) exp_first = rd_addr_q;
            exp_err++;
          end
          rd_pend = 0;
        end else rd_delay--;
      end
      cmd_ready = (($urandom % 100) < ready_pct);
      if (rst_n) begin
        if (prev_stall)
          chk(cmd_valid && cmd_op == prev_op && cmd_addr == prev_addr, "R13 hold",
              {46'h0, cmd_valid, cmd_op, cmd_addr}, {46'h0, 1'b1, prev_op, prev_addr});
        prev_stall = cmd_valid && !cmd_ready;
        prev_op    = cmd_op;
        prev_addr  = cmd_addr;
        if (cmd_valid && cmd_ready) begin
          if (cmd_op == 2'd0) begin
            chk(phase == 0, "R2 act order", 64'(phase), 64'd0);
            if (seen_pre) chk(cyc - t_pre >= longint'(cfg_trp), "R6 trp", 64'(cyc - t_pre), 64'(cfg_trp));
            t_act = cyc; op_addr = cmd_addr; phase = 1;
          end else if (cmd_op == 2'd3) begin
            chk(phase == 2, "R2 pre order", 64'(phase), 64'd2);
            chk(cyc - t_act >= longint'(cfg_tras), "R4 tras", 64'(cyc - t_act), 64'(cfg_tras));
            if (col_wr) chk(cyc - t_col >= longint'(cfg_twr), "R5 twr", 64'(cyc - t_col), 64'(cfg_twr));
            t_pre = cyc; seen_pre = 1; phase = 0;
          end else begin
            chk(phase == 1 && cmd_addr == op_addr, "R2 column order", {48'h0, cmd_addr}, {48'h0, op_addr});
            chk(cyc - t_act >= longint'(cfg_trcd), "R3 trcd", 64'(cyc - t_act), 64'(cfg_trcd));
            chk(int'(cmd_addr) >= base_i && int'(cmd_addr) < base_i + lines_i, "R8 address range",
                {48'h0, cmd_addr}, 64'(base_i));
            t_col = cyc; phase = 2; col_wr = (cmd_op == 2'd1);
            if (col_wr) begin
              chk(cmd_wdata == exp_pat(cfg_pattern, cmd_addr), "R7 pattern", cmd_wdata, exp_pat(cfg_pattern, cmd_addr));
              chk(!wr_seen[cmd_addr[9:0]], "R8 single write", 64'(wr_seen[cmd_addr[9:0]]), 64'd0);
              wr_seen[cmd_addr[9:0]] = 1; wr_t[cmd_addr[9:0]] = cyc;
              mem[cmd_addr[9:0]] = cmd_wdata;
              writes_done++; outstanding++;
              if (outstanding > max_out) max_out = outstanding;
              chk(outstanding <= NSLOT, "R10 slot limit", 64'(outstanding), 64'(NSLOT));
            end else begin
              chk(wr_seen[cmd_addr[9:0]] && !rd_seen[cmd_addr[9:0]], "R8 read after write once",
                  64'(rd_seen[cmd_addr[9:0]]), 64'd0);
              if (wait_i > 0)
                chk(cyc - wr_t[cmd_addr[9:0]] >= longint'((wait_i - 1) * (pre_i + 1)), "R9 retention gap",
                    64'(cyc - wr_t[cmd_addr[9:0]]), 64'((wait_i - 1) * (pre_i + 1)));
              rd_seen[cmd_addr[9:0]] = 1;
              reads_done++; outstanding--;
              rd_pend = 1; rd_delay = int'($urandom % 4); rd_addr_q = cmd_addr;
            end
          end
        end
      end
    end
  end

  task automatic run(input logic [1:0] pat, input int base, input int lines, input int waitt, input int pre,
                     input int trcd, input int tras, input int twr, input int trp, input int pct,
                     input int bad_pct, output int mo);
    int n;
    @(negedge clk);
    cfg_pattern = pat; cfg_base = AW'(base); cfg_lines = LCW'(lines);
    cfg_wait = TW'(waitt); cfg_prescale = PW'(pre);
    cfg_trcd = TCW'(trcd); cfg_tras = TCW'(tras); cfg_twr = TCW'(twr); cfg_trp = TCW'(trp);
    base_i = base; lines_i = lines; wait_i = waitt; pre_i = pre; ready_pct = pct;
    for (int a = 0; a < 1024; a++) begin
      wr_seen[a] = 0; rd_seen[a] = 0;
      flip[a] = (($urandom % 100) < bad_pct) ? (64'h1 << ($urandom % 64)) : 64'h0;
    end
    outstanding = 0; max_out = 0; reads_done = 0; writes_done = 0; exp_err = 0; exp_first = '0; phase = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && err_count == '0 && first_fail_addr == '0, "R12 start clears",
        {32'h0, err_count[29:0], busy, done}, 64'h2);
    n = 0;
    while (!done && n < 30000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R12 watchdog", 64'(done), 64'd1);
    chk(!busy && !rd_pend && reads_done == lines, "R12 done after verify", 64'(reads_done), 64'(lines));
    chk(writes_done == lines, "R8 write count", 64'(writes_done), 64'(lines));
    chk(err_count == ERRW'(exp_err), "R11 error count", 64'(err_count), 64'(exp_err));
    chk(first_fail_addr == (exp_err > 0 ? exp_first : 16'h0), "R11 first fail",
        {48'h0, first_fail_addr}, {48'h0, (exp_err > 0 ? exp_first : 16'h0)});
    repeat (4) @(negedge clk);
    chk(done && !cmd_valid && !busy, "R12 done holds", {62'h0, done, cmd_valid}, 64'h2);
    mo = max_out;
  endtask

  initial begin
    int mo;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !cmd_valid && err_count == '0 && first_fail_addr == '0, "R1 reset state",
        {61'h0, busy, done, cmd_valid}, 64'h0);

    run(2'd0, 16, 12, 20, 3, 3, 8, 4, 3, 100, 0, mo);
    chk(mo >= 2, "R10 overlap", 64'(mo), 64'd2);
    run(2'd1, 100, 8, 60, 7, 2, 6, 5, 2, 100, 0, mo);
    chk(mo == NSLOT, "R10 full occupancy", 64'(mo), 64'(NSLOT));
    run(2'd2, 301, 20, 5, 1, 1, 1, 1, 1, 70, 30, mo);
    run(2'd3, 500, 25, 40, 3, 5, 12, 7, 4, 60, 25, mo);
    run(2'd3, 700, 40, 60, 7, 4, 10, 6, 3, 80, 0, mo);
    chk(mo == NSLOT, "R10 full occupancy long run", 64'(mo), 64'(NSLOT));
    run(2'd2, 40, 0, 10, 2, 2, 2, 2, 2, 100, 0, mo);
    chk(writes_done == 0, "R12 empty run", 64'(writes_done), 64'd0);
    run(2'd1, 900, 1, 0, 0, 1, 3, 2, 1, 50, 100, mo);
    for (int k = 0; k < 4; k++) begin
      run(2'($urandom % 4), int'($urandom % 900), int'($urandom % 40), int'($urandom % 30),
          int'($urandom % 4), int'(1 + $urandom % 10), int'(1 + $urandom % 20), int'(1 + $urandom % 10),
          int'(1 + $urandom % 10), int'(40 + $urandom % 61), int'($urandom % 40), mo);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule